// File: doc/BRIEF.md
# Two-Bit Pin Sense and Event Unit

This unit watches 32 already-synchronised pin levels and turns selected transitions into sticky event bits. Every pin has its own two-bit sense code choosing any-edge, rising-only or falling-only detection, or none at all. The codes for the lower sixteen pins share one 32-bit register and those for the upper sixteen share a second one. In both, the lowest-numbered pin of the half holds the most significant field. Events accumulate in a write-one-to-clear register. A mask register picks which events drive the single interrupt line.

The unit also holds the pin direction register. The top four pins can only ever be inputs, so their direction bits are fixed at zero. Software reaches every register through one write port and one combinational read port, both addressed by byte offset.

Edge detection is run by a two-state sequencer. After reset it sits in `SEED` for exactly one clock, capturing the current pin levels as the reference without reporting any event. It then takes the transition `SEED -> LIVE` and stays in `LIVE` (`LIVE -> LIVE`) until the next reset. This keeps reset-time pin levels from appearing as false edges.

Top module: `pin_sense_unit`

## Requirements
- R1: After reset the direction, event, mask and both sense registers read 0 and `irq` is low.
- R2: Offsets are 0x00 direction, 0x0C events, 0x10 mask, 0x14 lower sense, 0x18 upper sense. In the direction, event and mask registers pin p sits at bit 31−p. Reads of any other offset return 0.
- R3: Sense fields for pins 0–15 are in the register at 0x14 and those for pins 16–31 are in the register at 0x18. The field for pin p occupies bits 2·(15−(p mod 16))+1 down to 2·(15−(p mod 16)).
- R4: Sense code 00 records both rising and falling transitions of the pin.
- R5: Sense code 01 records only low-to-high transitions.
- R6: Sense code 10 records only high-to-low transitions.
- R7: Sense code 11 records nothing, whatever the pin does.
- R8: A level change seen at one clock edge appears in the event register right after that edge. The first clock after reset (state `SEED`) records no events.
- R9: Writing the event register clears the bits written as 1. Bits written as 0 keep their value.
- R10: When a pin's event is set in the same cycle that a write clears its bit, the bit ends up set.
- R11: `irq` is high exactly when some event bit is set and its mask bit, at the same position, is 1.
- R12: Direction bits for pins 28–31 are always 0. Writes to them are ignored and they read back as 0, so `dir_out[31:28]` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 32 | Synchronised pin levels, bit p is pin p |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| dir_out | output | 32 | Pin direction, bit p is pin p, 1 = output |
| irq | output | 1 | Masked event interrupt |

## Verification
Two things can land on the same event bit in the same clock: a detected edge setting it, and a software write clearing it. The bench forces this on purpose. It toggles a pin in the very cycle that it writes a one to that pin's event bit, and it expects the bit to stay set. The random phase creates many more such collisions by mixing random writes to the event register with random pin flips, and it judges each cycle against a model where the set is applied after the clear. A sense-register write that coincides with an edge is judged the same way: the code in force before that write decides whether the edge is recorded.

// File: rtl/pin_sense_pkg.sv
`timescale 1ns/1ps
package pin_sense_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DIR    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_EVT    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_SNS_LO = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_SNS_HI = 5'h18;

    typedef enum logic [1:0] {
        SNS_ANY  = 2'b00,
        SNS_RISE = 2'b01,
        SNS_FALL = 2'b10,
        SNS_OFF  = 2'b11
    } sense_e;

    typedef enum logic {
        ST_SEED = 1'b0,
        ST_LIVE = 1'b1
    } arm_e;

endpackage

// File: rtl/psu_regs.sv
`timescale 1ns/1ps
module psu_regs
    import pin_sense_pkg::*;
#(
    parameter int NPINS         = 32,
    parameter int FIRST_IN_ONLY = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NPINS-1:0]  evt_pin,
    output logic [NPINS-1:0]  rd_data,
    output logic [NPINS-1:0]  dir_pin,
    output logic [NPINS-1:0]  mask_pin,
    output logic [NPINS-1:0]  clr_pin,
    output logic [NPINS-1:0]  sense_lo,
    output logic [NPINS-1:0]  sense_hi
);

    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] sns_lo_q;
    logic [NPINS-1:0] sns_hi_q;
    logic [NPINS-1:0] wr_pin;
    logic [NPINS-1:0] dir_reg;
    logic [NPINS-1:0] evt_reg;
    logic [NPINS-1:0] mask_reg;
    logic             hit_dir;
    logic             hit_evt;
    logic             hit_mask;
    logic             hit_lo;
    logic             hit_hi;

    assign hit_dir  = wr_en && (wr_addr == OFS_DIR);
    assign hit_evt  = wr_en && (wr_addr == OFS_EVT);
    assign hit_mask = wr_en && (wr_addr == OFS_MASK);
    assign hit_lo   = wr_en && (wr_addr == OFS_SNS_LO);
    assign hit_hi   = wr_en && (wr_addr == OFS_SNS_HI);

    // register bit 31-p carries pin p
    assign wr_pin = {<<{wr_data}};

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_dir
            if (p < FIRST_IN_ONLY) begin : g_rw
                logic dir_bit;
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        dir_bit <= 1'b0;
                    else if (hit_dir)
                        dir_bit <= wr_pin[p];
                end
                assign dir_pin[p] = dir_bit;
            end else begin : g_ro
                assign dir_pin[p] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            sns_lo_q <= '0;
            sns_hi_q <= '0;
        end else begin
            if (hit_mask)
                mask_q <= wr_pin;
            if (hit_lo)
                sns_lo_q <= wr_data;
            if (hit_hi)
                sns_hi_q <= wr_data;
        end
    end

    assign clr_pin  = hit_evt ? wr_pin : '0;
    assign mask_pin = mask_q;
    assign sense_lo = sns_lo_q;
    assign sense_hi = sns_hi_q;

    assign dir_reg  = {<<{dir_pin}};
    assign evt_reg  = {<<{evt_pin}};
    assign mask_reg = {<<{mask_q}};

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_DIR:    rd_data = dir_reg;
            OFS_EVT:    rd_data = evt_reg;
            OFS_MASK:   rd_data = mask_reg;
            OFS_SNS_LO: rd_data = sns_lo_q;
            OFS_SNS_HI: rd_data = sns_hi_q;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/psu_edge.sv
`timescale 1ns/1ps
module psu_edge
    import pin_sense_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] sense_lo,
    input  logic [NPINS-1:0] sense_hi,
    output logic [NPINS-1:0] set_pin,
    output logic             live
);

    localparam int HALF = NPINS / 2;

    arm_e             state_q;
    arm_e             state_d;
    logic [NPINS-1:0] prev_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_SEED;
        else
            state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        live    = 1'b0;
        unique case (state_q)
            ST_SEED: begin
                state_d = ST_LIVE;
                live    = 1'b0;
            end
            ST_LIVE: begin
                state_d = ST_LIVE;
                live    = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= pin_lvl;
    end

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            localparam int SH = 2 * (HALF - 1 - (p % HALF));
            logic [1:0] code;
            logic       rise;
            logic       fall;
            logic       hit;

            if (p < HALF) begin : g_lo
                assign code = sense_lo[SH+1:SH];
            end else begin : g_hi
                assign code = sense_hi[SH+1:SH];
            end

            assign rise = pin_lvl[p] & ~prev_q[p];
            assign fall = ~pin_lvl[p] & prev_q[p];

            always_comb begin
                unique case (sense_e'(code))
                    SNS_ANY:  hit = rise | fall;
                    SNS_RISE: hit = rise;
                    SNS_FALL: hit = fall;
                    SNS_OFF:  hit = 1'b0;
                endcase
            end

            assign set_pin[p] = live & hit;
        end
    endgenerate

endmodule

// File: rtl/psu_events.sv
`timescale 1ns/1ps
module psu_events #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] set_pin,
    input  logic [NPINS-1:0] clr_pin,
    input  logic [NPINS-1:0] mask_pin,
    output logic [NPINS-1:0] evt_pin,
    output logic             irq
);

    logic [NPINS-1:0] evt_q;

    // clear first, then set: a new event survives a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= '0;
        else
            evt_q <= (evt_q & ~clr_pin) | set_pin;
    end

    assign evt_pin = evt_q;
    assign irq     = |(evt_q & mask_pin);

endmodule

// File: rtl/pin_sense_unit.sv
`timescale 1ns/1ps
module pin_sense_unit
    import pin_sense_pkg::*;
#(
    parameter int NPINS         = 32,
    parameter int FIRST_IN_ONLY = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       pin_lvl,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [31:0]       dir_out,
    output logic              irq
);

    logic [NPINS-1:0] set_pin;
    logic [NPINS-1:0] clr_pin;
    logic [NPINS-1:0] evt_pin;
    logic [NPINS-1:0] mask_pin;
    logic [NPINS-1:0] sense_lo;
    logic [NPINS-1:0] sense_hi;
    logic             live;

    psu_regs #(
        .NPINS         (NPINS),
        .FIRST_IN_ONLY (FIRST_IN_ONLY)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .evt_pin  (evt_pin),
        .rd_data  (rd_data),
        .dir_pin  (dir_out),
        .mask_pin (mask_pin),
        .clr_pin  (clr_pin),
        .sense_lo (sense_lo),
        .sense_hi (sense_hi)
    );

    psu_edge #(
        .NPINS (NPINS)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl),
        .sense_lo (sense_lo),
        .sense_hi (sense_hi),
        .set_pin  (set_pin),
        .live     (live)
    );

    psu_events #(
        .NPINS (NPINS)
    ) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pin  (set_pin),
        .clr_pin  (clr_pin),
        .mask_pin (mask_pin),
        .evt_pin  (evt_pin),
        .irq      (irq)
    );

endmodule

// File: rtl/pin_sense_unit_chk.sv
`timescale 1ns/1ps
module pin_sense_unit_chk
    import pin_sense_pkg::*;
#(
    parameter int NPINS         = 32,
    parameter int FIRST_IN_ONLY = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       dir_out,
    input logic              irq,
    input logic [NPINS-1:0]  set_pin,
    input logic [NPINS-1:0]  evt_pin,
    input logic [NPINS-1:0]  sense_lo,
    input logic [NPINS-1:0]  sense_hi,
    input logic              live
);

    AST_SEED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> set_pin == '0); // R8

    AST_SEED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> live); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_lo == '1 && sense_hi == '1) |-> set_pin == '0); // R7

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_EVT && wr_data == '1 && set_pin == '0) |=> evt_pin == '0); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pin != '0) |=> ((evt_pin & $past(set_pin)) == $past(set_pin))); // R10

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> evt_pin != '0); // R11

    AST_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_DIR) |=> dir_out[NPINS-1:FIRST_IN_ONLY] == '0); // R12

endmodule

bind pin_sense_unit pin_sense_unit_chk #(
    .NPINS         (NPINS),
    .FIRST_IN_ONLY (FIRST_IN_ONLY)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .dir_out  (dir_out),
    .irq      (irq),
    .set_pin  (set_pin),
    .evt_pin  (evt_pin),
    .sense_lo (sense_lo),
    .sense_hi (sense_hi),
    .live     (live)
);

// File: tb/test_pin_sense_unit.sv
`timescale 1ns/1ps
module test_pin_sense_unit;
    import pin_sense_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pin_lvl;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [4:0]  rd_addr;
    logic [31:0] rd_data;
    logic [31:0] dir_out;
    logic        irq;

    always #2.5 clk = ~clk;

    pin_sense_unit i_pin_sense_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (pin_lvl),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .dir_out (dir_out),
        .irq     (irq)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // model, register-domain (bit 31-p = pin p)
    logic [31:0] m_prev, m_dir, m_evt, m_mask, m_lo, m_hi;
    logic        m_armed;

    function automatic logic [31:0] exp_hits(logic [31:0] lvl, logic [31:0] prv,
                                             logic [31:0] lo, logic [31:0] hi);
        logic [31:0] v = '0;
        for (int p = 0; p < 32; p++) begin
            logic [31:0] s = (p < 16) ? lo : hi;
            int          sh = 2 * (15 - (p % 16));
            logic [1:0]  c = s[sh +: 2];
            logic        r = lvl[p] & ~prv[p];
            logic        f = ~lvl[p] & prv[p];
            logic        h = (c == 2'b00) ? (r | f) : (c == 2'b01) ? r : (c == 2'b10) ? f : 1'b0;
            v[31-p] = h;
        end
        return v;
    endfunction

    function automatic logic [31:0] flip(logic [31:0] x);
        logic [31:0] y;
        for (int i = 0; i < 32; i++) y[i] = x[31-i];
        return y;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    // drive one cycle from just after a falling edge, update model at the rising edge
    task automatic step(input logic [31:0] lvl, input logic we,
                        input logic [4:0] a, input logic [31:0] d);
        logic [31:0] set, clr;
        pin_lvl = lvl;
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        set = m_armed ? exp_hits(lvl, m_prev, m_lo, m_hi) : '0;
        clr = (we && a == OFS_EVT) ? d : '0;
        m_evt = (m_evt & ~clr) | set;
        if (we && a == OFS_DIR)    m_dir  = d & 32'hFFFF_FFF0;
        if (we && a == OFS_MASK)   m_mask = d;
        if (we && a == OFS_SNS_LO) m_lo   = d;
        if (we && a == OFS_SNS_HI) m_hi   = d;
        m_prev  = lvl;
        m_armed = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_state(input string req);
        logic [31:0] v;
        rd(OFS_EVT, v);
        check({req, " event"}, v, m_evt);
        check({req, " irq"}, {31'b0, irq}, {31'b0, |(m_evt & m_mask)});
        rd(OFS_DIR, v);
        check({req, " dir"}, v, m_dir);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lvl;
        void'($urandom(32'd24680));
        rst_n = 1'b0; pin_lvl = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        m_prev = '0; m_dir = '0; m_evt = '0; m_mask = '0; m_lo = '0; m_hi = '0; m_armed = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(OFS_DIR, v);    check("R1 dir", v, 32'h0);
        rd(OFS_EVT, v);    check("R1 evt", v, 32'h0);
        rd(OFS_MASK, v);   check("R1 mask", v, 32'h0);
        rd(OFS_SNS_LO, v); check("R1 sense lo", v, 32'h0);
        rd(OFS_SNS_HI, v); check("R1 sense hi", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R8 seed cycle ignores the first sample
        step(32'hFFFF_FFFF, 1'b0, 5'h0, 32'h0);
        check_state("R8 seed");
        // R4 any edge on every pin after reset
        step(32'h0000_0000, 1'b0, 5'h0, 32'h0);
        check_state("R4 any-edge");
        rd(OFS_EVT, v); check("R8 one-cycle latency", v, 32'hFFFF_FFFF);

        // R2 unmapped offsets read zero
        step(32'h0, 1'b1, 5'h04, 32'hDEAD_BEEF);
        rd(5'h04, v); check("R2 unmapped 04", v, 32'h0);
        rd(5'h08, v); check("R2 unmapped 08", v, 32'h0);

        // R9 partial clear, zeros keep
        step(32'h0, 1'b1, OFS_EVT, 32'h0000_FFFF);
        check_state("R9 partial clear");
        step(32'h0, 1'b1, OFS_EVT, 32'h0);
        check_state("R9 zero write");

        // R11 mask enables irq for pin 0 (bit 31)
        step(32'h0, 1'b1, OFS_MASK, 32'h8000_0000);
        check("R11 irq on", {31'b0, irq}, 32'h1);
        step(32'h0, 1'b1, OFS_EVT, 32'h8000_0000);
        check("R11 irq off", {31'b0, irq}, 32'h0);
        step(32'h0, 1'b1, OFS_EVT, 32'hFFFF_FFFF);

        // R3 R5 R6: pin 0 rising (bits 31:30 = 01), pin 31 falling (bits 1:0 = 10)
        step(32'h0, 1'b1, OFS_SNS_LO, 32'h7FFF_FFFF);
        step(32'h0, 1'b1, OFS_SNS_HI, 32'hFFFF_FFFE);
        step(32'h8000_0001, 1'b0, 5'h0, 32'h0);
        rd(OFS_EVT, v); check("R3 R5 pin0 rise", v, 32'h8000_0000);
        step(32'h0000_0000, 1'b0, 5'h0, 32'h0);
        rd(OFS_EVT, v); check("R3 R6 pin31 fall", v, 32'h8000_0001);
        check_state("R5 R6 model");

        // R7 reserved code
        step(32'h0, 1'b1, OFS_SNS_LO, 32'hFFFF_FFFF);
        step(32'h0, 1'b1, OFS_SNS_HI, 32'hFFFF_FFFF);
        step(32'h0, 1'b1, OFS_EVT, 32'hFFFF_FFFF);
        step(32'hFFFF_FFFF, 1'b0, 5'h0, 32'h0);
        step(32'h0, 1'b0, 5'h0, 32'h0);
        rd(OFS_EVT, v); check("R7 no events", v, 32'h0);

        // R10 set beats clear on pin 5 (bit 26)
        step(32'h0, 1'b1, OFS_SNS_LO, 32'h0);
        step(32'h0, 1'b1, OFS_SNS_HI, 32'h0);
        step(32'h0000_0020, 1'b0, 5'h0, 32'h0);
        step(32'h0000_0000, 1'b1, OFS_EVT, 32'h0400_0000);
        rd(OFS_EVT, v); check("R10 set wins", v, 32'h0400_0000);

        // R12 input-only pins
        step(32'h0, 1'b1, OFS_DIR, 32'hFFFF_FFFF);
        rd(OFS_DIR, v); check("R12 dir readback", v, 32'hFFFF_FFF0);
        check("R12 dir_out", dir_out, 32'h0FFF_FFFF);

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [4:0] a;
            int         k = $urandom % 7;
            a = (k == 0) ? OFS_DIR : (k == 1) ? OFS_EVT : (k == 2) ? OFS_MASK :
                (k == 3) ? OFS_SNS_LO : (k == 4) ? OFS_SNS_HI : (k == 5) ? 5'h04 : 5'h08;
            lvl = m_prev ^ ($urandom & $urandom & $urandom);
            step(lvl, ($urandom % 3) == 0, a, $urandom);
            check_state("R4 R5 R6 R9 R10 random");
            check("R12 random dir_out", dir_out, flip(m_dir));
        end

        summary();
        $finish;
    end

endmodule